// File: doc/BRIEF.md
# Three-Byte Interrupt Status Aggregator

This block gathers 24 event sources into one level-high interrupt line for a host. The status word is split into three 8-bit bytes. When a source is high for a clock cycle, its status bit is set and stays set. Two mask banks control each bit. The status mask stops a source from setting its bit at all. The line mask lets the bit latch but keeps it from raising the interrupt line.

A byte-wide register port gives access to all nine registers: address, write enable, write data and a combinational read path. The three status bytes sit at consecutive addresses starting at zero, so a host can fetch the whole word with three reads in a row. The host acknowledges an interrupt with one byte write of any value to any status address, and that write clears all 24 status bits. A source event that lands in the same cycle as that write survives the clear.

The register port and the event inputs are plain control pins. They have no valid/ready handshake, because every access completes in one cycle and nothing is ever held back.

Top module: `irq_agg_top`

## Requirements
- R1: Source n maps to bit (n mod 8) of status byte n/8. Status byte A (sources 0 to 7) is at address 0x0, B at 0x1 and C at 0x2.
- R2: A source that is high during a cycle sets its status bit at that clock edge, provided its status mask bit is 0. The bit stays set through any later cycles until a clear.
- R3: The status mask bank is at addresses 0x6, 0x7 and 0x8, one byte per status byte in the same order. A status mask bit of 1 stops its source from setting the status bit. A bit of 0 lets it through.
- R4: The line mask bank is at addresses 0x3, 0x4 and 0x5. A line mask bit of 1 still lets the status bit latch, but that bit does not drive `irq_o`.
- R5: `irq_o` is registered. It equals the OR over all 24 bits of (status AND NOT line mask), and it follows a change in status or line mask one clock later.
- R6: A write of any data to address 0x0, 0x1 or 0x2 clears all three status bytes at that clock edge.
- R7: When a source event and a clearing write occur in the same cycle, the event wins: after the edge only the bits set by that cycle's events remain.
- R8: After reset, every mask bit is 1, every status bit is 0 and `irq_o` is 0.
- R9: Reads of addresses 0x9 to 0xF return 0x00. Writes to those addresses change no register.
- R10: A mask register reads back the last byte written to it. With every mask byte at 0xFF, no source sets status and `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 24 | Event inputs, one per source, sampled every cycle |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The bench builds the block with its default parameters: three bytes of eight bits and a 4-bit address. With these values the nine defined registers fill 0x0 to 0x8, and the seven unused codes 0x9 to 0xF are reachable for the out-of-range read and write checks. The same sizes place every source on a known byte and bit, so a table of mask and event patterns can predict each status byte and the interrupt level exactly. This covers single bits at both ends of the word, masking in only one bank, and masking in both banks at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register regions seen by the byte-wide register port
  typedef enum logic [1:0] {
    RGN_STATUS = 2'd0,
    RGN_LMASK  = 2'd1,
    RGN_SMASK  = 2'd2,
    RGN_NONE   = 2'd3
  } rgn_e;

endpackage

// File: rtl/irq_agg_mask_bank.sv
module irq_agg_mask_bank #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  localparam int IDXW  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int NBITS = NBYTES * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [BW-1:0]   wr_data,
  output logic [NBITS-1:0] mask
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BW-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '1;
      else if (wr_en && (int'(wr_idx) == b))
        byte_q <= wr_data;
    end

    assign mask[b*BW +: BW] = byte_q;
  end

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt,
  input  logic [NBITS-1:0] smask,
  input  logic             clr,
  output logic [NBITS-1:0] status
);

  logic [NBITS-1:0] set_vec;
  logic [NBITS-1:0] keep_vec;

  // events admitted by the status mask; they win over a clear
  assign set_vec  = evt & ~smask;
  assign keep_vec = clr ? '0 : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= '0;
    else
      status <= keep_vec | set_vec;
  end

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(evt & ~smask)) == '0); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status))); // R2

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status == $past(evt & ~smask))); // R6 R7

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  parameter int ADDR_W = 4,
  localparam int NBITS = NBYTES * BW,
  localparam int IDXW  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int NREG  = 3 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBITS-1:0]  src_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [BW-1:0]     reg_wdata,
  output logic [BW-1:0]     reg_rdata,
  output logic              irq_o
);
  import irq_agg_pkg::*;

  rgn_e             rgn;
  logic [IDXW-1:0]  idx;
  logic [NBITS-1:0] status;
  logic [NBITS-1:0] lmask;
  logic [NBITS-1:0] smask;
  logic             status_clr;
  logic             irq_q;

  // address decode: status bytes, then line masks, then status masks
  always_comb begin
    int a;
    int off;
    a   = int'(reg_addr);
    off = 0;
    rgn = RGN_NONE;
    if (a < NBYTES) begin
      rgn = RGN_STATUS;
      off = a;
    end else if (a < 2 * NBYTES) begin
      rgn = RGN_LMASK;
      off = a - NBYTES;
    end else if (a < NREG) begin
      rgn = RGN_SMASK;
      off = a - 2 * NBYTES;
    end
    idx = IDXW'(off);
  end

  assign status_clr = reg_we && (rgn == RGN_STATUS);

  irq_agg_status #(
    .NBITS (NBITS)
  ) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (src_evt),
    .smask  (smask),
    .clr    (status_clr),
    .status (status)
  );

  irq_agg_mask_bank #(
    .NBYTES (NBYTES),
    .BW     (BW)
  ) u_lmask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we && (rgn == RGN_LMASK)),
    .wr_idx  (idx),
    .wr_data (reg_wdata),
    .mask    (lmask)
  );

  irq_agg_mask_bank #(
    .NBYTES (NBYTES),
    .BW     (BW)
  ) u_smask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we && (rgn == RGN_SMASK)),
    .wr_idx  (idx),
    .wr_data (reg_wdata),
    .mask    (smask)
  );

  // read mux
  always_comb begin
    unique case (rgn)
      RGN_STATUS: reg_rdata = status[idx*BW +: BW];
      RGN_LMASK:  reg_rdata = lmask[idx*BW +: BW];
      RGN_SMASK:  reg_rdata = smask[idx*BW +: BW];
      default:    reg_rdata = '0;
    endcase
  end

  // registered interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else
      irq_q <= |(status & ~lmask);
  end

  assign irq_o = irq_q;

  AST_LINE_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&lmask) |-> !irq_o); // R4

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|status) |-> !irq_o); // R5

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= NREG) |-> (reg_rdata == '0)); // R9

endmodule

// File: tb/irq_agg_top_tb.sv
`timescale 1ns/1ps
module irq_agg_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_evt = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  // {status mask, line mask, events, expected status, expected irq}
  localparam int NV = 7;
  localparam logic [96:0] VEC [NV] = '{
    {24'h000000, 24'h000000, 24'h000001, 24'h000001, 1'b1},
    {24'h000000, 24'hFFFFFF, 24'h800000, 24'h800000, 1'b0},
    {24'h0000FF, 24'h000000, 24'h0000FF, 24'h000000, 1'b0},
    {24'hFF0000, 24'h00FF00, 24'hA5A5A5, 24'h00A5A5, 1'b1},
    {24'h000000, 24'h7FFFFF, 24'h800100, 24'h800100, 1'b1},
    {24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b0},
    {24'h000000, 24'h00FF00, 24'h000100, 24'h000100, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [23:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic set_masks(input logic [23:0] sm, input logic [23:0] lm);
    for (int i = 0; i < 3; i++) begin
      wr(4'(6 + i), sm[i*8 +: 8]);
      wr(4'(3 + i), lm[i*8 +: 8]);
    end
  endtask

  task automatic read_status(output logic [23:0] s);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin
      rd(4'(i), b);
      s[i*8 +: 8] = b;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] s;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), b);
      check(i < 3 ? "R8 status reset" : "R8 mask reset", {24'h0, b}, i < 3 ? 32'h00 : 32'hFF);
    end
    check("R8 irq reset", {31'h0, irq_o}, 32'h0);

    // R10: all masked, events have no effect
    pulse(24'hFFFFFF);
    read_status(s);
    check("R10 all masked status", {8'h0, s}, 32'h0);
    @(negedge clk);
    check("R10 all masked irq", {31'h0, irq_o}, 32'h0);

    // table walk: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      set_masks(VEC[v][96:73], VEC[v][72:49]);
      wr(4'h0, 8'h00);
      pulse(VEC[v][48:25]);
      @(negedge clk);
      read_status(s);
      check("R3/R4 vector status", {8'h0, s}, {8'h0, VEC[v][24:1]});
      check("R5 vector irq", {31'h0, irq_o}, {31'h0, VEC[v][0]});
    end

    // R1: source 10 lands in byte B bit 2
    set_masks(24'h000000, 24'h000000);
    wr(4'h2, 8'h77);
    pulse(24'h000400);
    rd(4'h0, b); check("R1 byte A", {24'h0, b}, 32'h00);
    rd(4'h1, b); check("R1 byte B", {24'h0, b}, 32'h04);
    rd(4'h2, b); check("R1 byte C", {24'h0, b}, 32'h00);

    // R2: sticky and accumulating
    repeat (5) @(negedge clk);
    pulse(24'h010000);
    read_status(s);
    check("R2 sticky accumulate", {8'h0, s}, 32'h010400);

    // R6: write any data to byte C clears everything
    wr(4'h2, 8'h5A);
    read_status(s);
    check("R6 clear via C", {8'h0, s}, 32'h0);

    // R5: irq timing, one cycle after status
    @(negedge clk);
    src_evt = 24'h020000;
    @(negedge clk);
    src_evt = '0;
    check("R5 irq not yet", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R5 irq rises", {31'h0, irq_o}, 32'h1);
    wr(4'h1, 8'hC3);
    check("R5 irq still high after clear edge", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    check("R5 irq falls", {31'h0, irq_o}, 32'h0);

    // R4: line mask change drops irq one cycle later, status kept
    pulse(24'h000080);
    @(negedge clk);
    check("R4 irq before line mask", {31'h0, irq_o}, 32'h1);
    wr(4'h3, 8'h80);
    @(negedge clk);
    check("R4 irq after line mask", {31'h0, irq_o}, 32'h0);
    rd(4'h0, b);
    check("R4 status kept", {24'h0, b}, 32'h80);

    // R7: event and clear in the same cycle
    pulse(24'h000003);
    @(negedge clk);
    reg_addr = 4'h0; reg_wdata = 8'hFF; reg_we = 1'b1;
    src_evt = 24'h000020;
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
    read_status(s);
    check("R7 event beats clear", {8'h0, s}, 32'h000020);

    // R10: mask readback
    wr(4'h4, 8'h3C);
    rd(4'h4, b);
    check("R10 line mask readback", {24'h0, b}, 32'h3C);
    wr(4'h8, 8'hA1);
    rd(4'h8, b);
    check("R10 status mask readback", {24'h0, b}, 32'hA1);

    // R9: out-of-range writes have no effect, reads return zero
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h00);
    rd(4'h4, b); check("R9 lmask untouched", {24'h0, b}, 32'h3C);
    rd(4'h8, b); check("R9 smask untouched", {24'h0, b}, 32'hA1);
    read_status(s);
    check("R9 status untouched", {8'h0, s}, 32'h000020);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), b);
      check("R9 out-of-range read", {24'h0, b}, 32'h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule